// File: doc/BRIEF.md
# Carry-Save Tree Unsigned Multiplier

This block multiplies two unsigned N-bit operands and returns the full 2N-bit product. Every partial-product row is made at the same time: row j is the multiplicand gated by bit j of the multiplier and moved up by j places. The rows are then reduced in a balanced tree of 3:2 carry-save stages. Each stage turns three vectors into a sum vector and a carry vector. The carry vector is one place more significant than the sum vector. No carry moves from bit to bit inside a stage. A stage level only gathers rows in groups of three. Rows left over from a level pass through unchanged to the next level. The level loop stops when two vectors remain.

Those two vectors go into one 2N-bit parallel-prefix carry-propagate adder. Its carry-out is dropped, because the product always fits in 2N bits. The parameter REG_OUT selects the output path. When it is set, the product goes through one output register that has a clock enable and an asynchronous active-low reset. When it is clear, the product is driven combinationally. The tree shape is derived from N at elaboration, so any width of one bit or more builds.

Top module: `csa_tree_mult`

## Requirements
- R1: `prod` equals the unsigned product of `mcand` and `mplier` across the full operand range, in 2N bits with no truncation.
- R2: With REG_OUT=1, `prod` takes the product of the operands presented at a rising clock edge where `load` is high, and changes at that edge, not before.
- R3: While `load` is low, `prod` keeps its value whatever the operands do.
- R4: While `rst_n` is low, `prod` is zero, and driving `rst_n` low clears it without waiting for a clock edge.
- R5: A zero in either operand gives a zero product.
- R6: All-ones operands give (2^N-1)^2, for N=16 this is 0xFFFE0001, and its top bit is set.
- R7: A one-hot multiplicand 2^i times a one-hot multiplier 2^j gives exactly 2^(i+j), which exercises every partial-product row position.
- R8: The tree builds correctly for a small width (N=4, all 256 operand pairs) and for a wide one (N=16).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| load | input | 1 | Clock enable of the output register |
| mcand | input | N | Unsigned multiplicand |
| mplier | input | N | Unsigned multiplier |
| prod | output | 2N | Unsigned product |

## Verification
With the output register present, each product is due at the first rising edge after its operands are driven with `load` high. No other result has this one-cycle latency. The bench drives operands on the falling edge and reads `prod` on the next falling edge. For R2 it also reads `prod` just after driving, to confirm the old value is still showing. The reset effect is due at once, so the R4 check reads one nanosecond after `rst_n` falls, with no edge in between. The hold check reads across two idle edges while the operands change.

// File: rtl/csa_mult_pkg.sv
package csa_mult_pkg;

  // Rows still present after lv reduction levels, starting from n rows.
  function automatic int rows_after(input int n, input int lv);
    int r;
    r = n;
    for (int i = 0; i < lv; i++) r = 2 * (r / 3) + (r % 3);
    return r;
  endfunction

  // Number of 3:2 levels needed to bring n rows down to two (or fewer).
  function automatic int tree_levels(input int n);
    int r;
    int c;
    r = n;
    c = 0;
    while (r > 2) begin
      r = 2 * (r / 3) + (r % 3);
      c++;
    end
    return c;
  endfunction

endpackage

// File: rtl/csa32.sv
module csa32 #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] s,
  output logic [W-1:0] c
);
  // Independent full adder per bit; carry vector weighted one place up.
  assign s = x ^ y ^ z;
  assign c = {(x[W-2:0] & y[W-2:0]) | (x[W-2:0] & z[W-2:0]) | (y[W-2:0] & z[W-2:0]), 1'b0};
endmodule

// File: rtl/cpa_prefix.sv
module cpa_prefix #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] sum
);
  logic [W-1:0] hp;
  logic [W-1:0] gg;
  logic [W-1:0] pp;

  assign hp = x ^ y;

  // Log-depth prefix of generate/propagate pairs, carry-in fixed at zero.
  always_comb begin
    gg = x & y;
    pp = hp;
    for (int d = 1; d < W; d = d * 2) begin
      for (int i = W - 1; i >= d; i--) begin
        gg[i] = gg[i] | (pp[i] & gg[i-d]);
        pp[i] = pp[i] & pp[i-d];
      end
    end
  end

  // Carry into bit i is the group generate of bits 0..i-1; carry-out dropped.
  assign sum = hp ^ {gg[W-2:0], 1'b0};
endmodule

// File: rtl/csa_tree.sv
module csa_tree #(
  parameter int N = 8
) (
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic [2*N-1:0] vec_a,
  output logic [2*N-1:0] vec_b
);
  localparam int W      = 2 * N;
  localparam int LEVELS = csa_mult_pkg::tree_levels(N);

  logic [N-1:0][W-1:0] rows0;

  // Partial products, all rows at once.
  for (genvar j = 0; j < N; j++) begin : g_pp
    assign rows0[j] = W'(mcand & {N{mplier[j]}}) << j;
  end

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int RIN  = csa_mult_pkg::rows_after(N, l);
    localparam int GRP  = RIN / 3;
    localparam int LEFT = RIN % 3;
    localparam int ROUT = 2 * GRP + LEFT;

    logic [RIN-1:0][W-1:0]  cur;
    logic [ROUT-1:0][W-1:0] nxt;

    if (l == 0) begin : g_src0
      assign cur = rows0;
    end else begin : g_srcn
      assign cur = g_lvl[l-1].nxt;
    end

    for (genvar g = 0; g < GRP; g++) begin : g_csa
      csa32 #(.W(W)) u_csa (
        .x (cur[3*g]),
        .y (cur[3*g+1]),
        .z (cur[3*g+2]),
        .s (nxt[2*g]),
        .c (nxt[2*g+1])
      );
    end

    for (genvar k = 0; k < LEFT; k++) begin : g_pass
      assign nxt[2*GRP+k] = cur[3*GRP+k];
    end
  end

  if (LEVELS == 0) begin : g_flat
    assign vec_a = rows0[0];
    if (N > 1) begin : g_two
      assign vec_b = rows0[N-1];
    end else begin : g_one
      assign vec_b = '0;
    end
  end else begin : g_tree
    assign vec_a = g_lvl[LEVELS-1].nxt[0];
    assign vec_b = g_lvl[LEVELS-1].nxt[1];
  end
endmodule

// File: rtl/csa_tree_mult.sv
module csa_tree_mult #(
  parameter int N       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [N-1:0]   mcand,
  input  logic [N-1:0]   mplier,
  output logic [2*N-1:0] prod
);
  localparam int W = 2 * N;

  logic [W-1:0] vec_a;
  logic [W-1:0] vec_b;
  logic [W-1:0] prod_c;

  csa_tree #(.N(N)) u_tree (
    .mcand  (mcand),
    .mplier (mplier),
    .vec_a  (vec_a),
    .vec_b  (vec_b)
  );

  cpa_prefix #(.W(W)) u_cpa (
    .x   (vec_a),
    .y   (vec_b),
    .sum (prod_c)
  );

  if (REG_OUT) begin : g_reg
    logic [W-1:0] prod_d;
    logic [W-1:0] prod_q;

    always_comb begin
      prod_d = prod_q;
      if (load) prod_d = prod_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prod_q <= '0;
      else        prod_q <= prod_d;
    end

    assign prod = prod_q;
  end else begin : g_comb
    assign prod = prod_c;
  end
endmodule

// File: rtl/csa_tree_mult_chk.sv
module csa_tree_mult_chk #(
  parameter int N       = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           load,
  input logic [N-1:0]   mcand,
  input logic [N-1:0]   mplier,
  input logic [2*N-1:0] prod
);
  localparam int W = 2 * N;

  logic [W-1:0] ref_w;
  assign ref_w = W'(mcand) * W'(mplier);

  if (REG_OUT) begin : g_seq
    // R1 R2: loaded product appears one edge later
    a_r1_loaded_product: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> prod == $past(ref_w));
    // R3: no load, no change
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(prod));
    // R4: reset holds output at zero
    a_r4_reset_zero: assert property (@(posedge clk)
      !rst_n |=> prod == '0);
    // R5: zero operand loads zero
    a_r5_zero_operand: assert property (@(posedge clk) disable iff (!rst_n)
      (load && (mcand == '0 || mplier == '0)) |=> prod == '0);
  end else begin : g_cmb
    a_r1_comb_product: assert property (@(posedge clk) disable iff (!rst_n)
      prod == ref_w);
    a_r5_comb_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (mcand == '0 || mplier == '0) |-> prod == '0);
    a_r6_comb_upper: assert property (@(posedge clk) disable iff (!rst_n)
      (mcand[N-1] && mplier[N-1]) |-> prod[W-1:W-2] != 2'b00);
    a_r4_comb_known: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(mcand) && !$isunknown(mplier) |-> !$isunknown(prod));
  end
endmodule

bind csa_tree_mult csa_tree_mult_chk #(.N(N), .REG_OUT(REG_OUT)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .load   (load),
  .mcand  (mcand),
  .mplier (mplier),
  .prod   (prod)
);

// File: tb/csa_tree_mult_bench.sv
`timescale 1ns/1ps
module csa_tree_mult_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load;
  logic [15:0] a16, b16;
  logic [31:0] p16;
  logic [3:0]  a4, b4;
  logic [7:0]  p4;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  csa_tree_mult #(.N(16), .REG_OUT(1'b1)) u_csa_tree_mult (
    .clk (clk), .rst_n (rst_n), .load (load),
    .mcand (a16), .mplier (b16), .prod (p16)
  );

  csa_tree_mult #(.N(4), .REG_OUT(1'b1)) u_csa_tree_mult_n4 (
    .clk (clk), .rst_n (rst_n), .load (load),
    .mcand (a4), .mplier (b4), .prod (p4)
  );

  // {mcand, mplier, expected}
  localparam logic [63:0] VEC [9] = '{
    {16'h0003, 16'h0002, 32'h0000_0006},
    {16'hFFFF, 16'hFFFF, 32'hFFFE_0001},
    {16'h0000, 16'hFFFF, 32'h0000_0000},
    {16'hFFFF, 16'h0001, 32'h0000_FFFF},
    {16'h8000, 16'h8000, 32'h4000_0000},
    {16'h1234, 16'h0010, 32'h0001_2340},
    {16'h00FF, 16'h0101, 32'h0000_FFFF},
    {16'h8000, 16'hFFFF, 32'h7FFF_8000},
    {16'h0100, 16'h0100, 32'h0001_0000}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  task automatic apply16(input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    a16 = a; b16 = b; load = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; load = 1'b0;
    a16 = '0; b16 = '0; a4 = '0; b4 = '0;
    repeat (3) @(negedge clk);
    chk("R4 reset n16", 64'(p16), 64'h0);
    chk("R4 reset n4", 64'(p4), 64'h0);
    rst_n = 1'b1;

    // R1: vector table
    for (int i = 0; i < 9; i++) begin
      apply16(VEC[i][63:48], VEC[i][47:32]);
      chk("R1 table", 64'(p16), 64'(VEC[i][31:0]));
    end

    // R5: zero operands
    apply16(16'h0000, 16'h0000);
    chk("R5 zero both", 64'(p16), 64'h0);
    apply16(16'hBEEF, 16'h0000);
    chk("R5 zero mplier", 64'(p16), 64'h0);

    // R6: all ones, top bit set
    apply16(16'hFFFF, 16'hFFFF);
    chk("R6 all ones", 64'(p16), 64'hFFFE_0001);
    chk("R6 msb", 64'(p16[31]), 64'h1);

    // R7: one-hot operands
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        apply16(16'(1) << i, 16'(1) << j);
        chk("R7 one-hot", 64'(p16), 64'(32'(1) << (i + j)));
      end
    end

    // R2: latency, new value only after the edge
    apply16(16'h0007, 16'h0003);
    a16 = 16'h0009; b16 = 16'h0009; load = 1'b1;
    #1;
    chk("R2 before edge", 64'(p16), 64'd21);
    @(negedge clk);
    chk("R2 after edge", 64'(p16), 64'd81);

    // R3: hold with load low while operands move
    load = 1'b0;
    a16 = 16'h1111; b16 = 16'h2222;
    @(negedge clk);
    a16 = 16'hFFFF; b16 = 16'h00F0;
    @(negedge clk);
    chk("R3 hold", 64'(p16), 64'd81);

    // R4: asynchronous clear mid-cycle
    rst_n = 1'b0;
    #1;
    chk("R4 async clear", 64'(p16), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;

    // R8: exhaustive N=4
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        @(negedge clk);
        a4 = 4'(x); b4 = 4'(y); load = 1'b1;
        @(negedge clk);
        chk("R8 exhaustive n4", 64'(p4), 64'(x * y));
      end
    end

    // R1 R8: random N=16
    for (int k = 0; k < 1000; k++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      rb = 16'($urandom);
      apply16(ra, rb);
      chk("R1 random n16", 64'(p16), 64'(32'(ra) * 32'(rb)));
    end

    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      summary();
    end
  end
endmodule